// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Triggering

This block is a bank of general-purpose pins with a small memory-mapped register interface. Software can make each pin an input or an output. It drives output levels through write-one-to-set and write-one-to-clear words, and it reads the synchronized pin levels back. All accesses use single-cycle write and read strobes with an address and data.

Every pin can also act as an interrupt source. The trigger for each pin is chosen with three bit planes:

- **Method plane:** picks edge detection or level detection.
- **Any-edge plane:** in edge mode, makes every transition count.
- **Polarity plane:** its meaning depends on the method. In edge mode it picks rising or falling. In level mode it picks active-high or active-low.

Edge triggers are latched until software writes ones to the clear word. Level triggers follow the pin. Latched triggers are gated by an enable plane and a mask plane, and the gated bits are ORed into one registered bank interrupt.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous reset, every register reads zero, `pin_oe`, `pin_out` and `bank_irq` are zero, and every pin is an input with interrupts disabled.
- R2: A write to offset 0x10 sets each output latch bit that has a one in `wdata`. A write to offset 0x14 clears those bits. Latch bits whose `wdata` bit is zero keep their value. A read of 0x10 or 0x14 returns the latch, and `pin_out` shows the latch one cycle after the write.
- R3: The direction word at 0x08 can be read and written. A 1 in bit i makes pin i an output, so `pin_oe[i]` is 1 one cycle after the write.
- R4: A read of 0x04 returns the pin levels after a two-flop synchronizer. A pin change becomes visible to a read strobe issued two or more cycles later.
- R5: With method bit (0x34) 0 and any-edge bit (0x38) 0, a polarity bit (0x3C) of 0 latches raw status (0x24) on a rising edge, and a polarity bit of 1 latches it on a falling edge.
- R6: With method bit 0 and any-edge bit 1, both a rising and a falling transition latch raw status, whatever the polarity bit holds.
- R7: With method bit 1, raw status follows the active level: pin high when the polarity bit is 0, pin low when it is 1. A write to the clear word has no lasting effect while the level stays active.
- R8: Writing to 0x30 clears the latched edge raw status bits at the positions of the ones in `wdata`. Bits with a zero are left as they are.
- R9: Masked status (0x28) reads raw AND enable (0x20) AND NOT mask (0x2C). `bank_irq` is the OR of all masked status bits, registered one cycle.
- R10: When an edge trigger and a clear write hit the same bit in the same cycle, the trigger wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | AW (8) | Byte offset of the register |
| wdata | input | NPINS (32) | Write data |
| rdata | output | NPINS (32) | Registered read data; holds between reads |
| pin_in | input | NPINS (32) | Pin levels from the pads |
| pin_out | output | NPINS (32) | Output latch towards the pads |
| pin_oe | output | NPINS (32) | Per-pin output enable (the direction word) |
| bank_irq | output | 1 | Combined bank interrupt |

## Verification
The two functions that can meet in one cycle are a pin's edge trigger and a software clear of that same status bit. The bench provokes the collision by changing a pin and placing the clear strobe exactly two clocks later, which is the cycle in which the synchronized edge reaches the status latch. The read that follows must still show the bit set. A clear issued one cycle later must then remove it. A behavioural reference model runs beside the design on every clock, so both the collision and the ordinary edge, level and gating paths are judged cycle by cycle against it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam logic [7:0] OFS_LEVEL  = 8'h04;
  localparam logic [7:0] OFS_DIR    = 8'h08;
  localparam logic [7:0] OFS_SET    = 8'h10;
  localparam logic [7:0] OFS_CLR    = 8'h14;
  localparam logic [7:0] OFS_ENA    = 8'h20;
  localparam logic [7:0] OFS_RAW    = 8'h24;
  localparam logic [7:0] OFS_MSKD   = 8'h28;
  localparam logic [7:0] OFS_MASK   = 8'h2C;
  localparam logic [7:0] OFS_ACK    = 8'h30;
  localparam logic [7:0] OFS_METHOD = 8'h34;
  localparam logic [7:0] OFS_ANYEDG = 8'h38;
  localparam logic [7:0] OFS_POLAR  = 8'h3C;

  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_method_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] level,
  output logic [W-1:0] level_prev
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign level      = sync_q;
  assign level_prev = prev_q;
endmodule

// File: rtl/gpio_trig.sv
module gpio_trig #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level,
  input  logic [W-1:0] level_prev,
  input  logic [W-1:0] method,
  input  logic [W-1:0] anyedge,
  input  logic [W-1:0] polarity,
  input  logic [W-1:0] ack,
  output logic [W-1:0] raw
);
  import gpio_bank_pkg::*;

  logic [W-1:0] raw_q;
  logic [W-1:0] hit;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall;
    assign rise = level[i] & ~level_prev[i];
    assign fall = ~level[i] & level_prev[i];

    always_comb begin
      if (anyedge[i]) hit[i] = rise | fall;
      else if (polarity[i]) hit[i] = fall;
      else hit[i] = rise;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        raw_q[i] <= 1'b0;
      end else if (trig_method_e'(method[i]) == TRIG_LEVEL) begin
        raw_q[i] <= level[i] ^ polarity[i];
      end else begin
        raw_q[i] <= hit[i] | (raw_q[i] & ~ack[i]);
      end
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (!method[i] && ack[i] && !hit[i]) |=> !raw[i]); // R8
    AST_HIT_WINS: assert property (@(posedge clk) disable iff (rst)
      (!method[i] && hit[i]) |=> raw[i]); // R10
    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!method[i] && raw[i] && !ack[i]) |=> raw[i]); // R5
  end

  assign raw = raw_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPINS = 32,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             bank_irq
);
  import gpio_bank_pkg::*;

  logic [NPINS-1:0] dir_q, out_q, ena_q, mask_q, meth_q, anye_q, pol_q;
  logic [NPINS-1:0] lvl, lvl_prev, raw, masked, ack, rd_mux, rdata_q;
  logic             irq_q;

  function automatic logic hit_ofs(input logic [AW-1:0] a, input logic [7:0] o);
    return a == AW'(o);
  endfunction

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in),
    .level(lvl), .level_prev(lvl_prev)
  );

  assign ack = (wr_en && hit_ofs(addr, OFS_ACK)) ? wdata : '0;

  gpio_trig #(.W(NPINS)) u_trig (
    .clk(clk), .rst(rst), .level(lvl), .level_prev(lvl_prev),
    .method(meth_q), .anyedge(anye_q), .polarity(pol_q),
    .ack(ack), .raw(raw)
  );

  assign masked = raw & ena_q & ~mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      out_q  <= '0;
      ena_q  <= '0;
      mask_q <= '0;
      meth_q <= '0;
      anye_q <= '0;
      pol_q  <= '0;
    end else if (wr_en) begin
      if (hit_ofs(addr, OFS_DIR))    dir_q  <= wdata;
      if (hit_ofs(addr, OFS_SET))    out_q  <= out_q | wdata;
      if (hit_ofs(addr, OFS_CLR))    out_q  <= out_q & ~wdata;
      if (hit_ofs(addr, OFS_ENA))    ena_q  <= wdata;
      if (hit_ofs(addr, OFS_MASK))   mask_q <= wdata;
      if (hit_ofs(addr, OFS_METHOD)) meth_q <= wdata;
      if (hit_ofs(addr, OFS_ANYEDG)) anye_q <= wdata;
      if (hit_ofs(addr, OFS_POLAR))  pol_q  <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ofs(addr, OFS_LEVEL))  rd_mux = lvl;
    if (hit_ofs(addr, OFS_DIR))    rd_mux = dir_q;
    if (hit_ofs(addr, OFS_SET))    rd_mux = out_q;
    if (hit_ofs(addr, OFS_CLR))    rd_mux = out_q;
    if (hit_ofs(addr, OFS_ENA))    rd_mux = ena_q;
    if (hit_ofs(addr, OFS_RAW))    rd_mux = raw;
    if (hit_ofs(addr, OFS_MSKD))   rd_mux = masked;
    if (hit_ofs(addr, OFS_MASK))   rd_mux = mask_q;
    if (hit_ofs(addr, OFS_METHOD)) rd_mux = meth_q;
    if (hit_ofs(addr, OFS_ANYEDG)) rd_mux = anye_q;
    if (hit_ofs(addr, OFS_POLAR))  rd_mux = pol_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_en) rdata_q <= rd_mux;
      irq_q <= |masked;
    end
  end

  assign rdata    = rdata_q;
  assign pin_out  = out_q;
  assign pin_oe   = dir_q;
  assign bank_irq = irq_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (hit_ofs(addr, OFS_SET) || hit_ofs(addr, OFS_CLR))) |=> $stable(pin_out)); // R2
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && hit_ofs(addr, OFS_DIR)) |=> $stable(pin_oe)); // R3
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    bank_irq |-> $past(|(ena_q & ~mask_q))); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && !bank_irq)); // R1
endmodule

// File: tb/sim_gpio_irq_bank.sv
`timescale 1ns/1ps
module sim_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, pin_in = '0;
  logic [31:0] rdata, pin_out, pin_oe;
  logic        bank_irq;

  int compared = 0, mismatched = 0;

  always #5 clk = ~clk;

  gpio_irq_bank #(.NPINS(32), .AW(8)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .bank_irq(bank_irq)
  );

  // Behavioural reference model
  logic [31:0] m_s1, m_s2, m_prev, m_dir, m_out, m_en, m_mask, m_meth, m_both, m_type, m_raw, m_rd;
  logic        m_irq;

  always @(posedge clk) begin
    logic [31:0] nraw;
    logic [31:0] rv;
    logic        hit;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_dir = 0; m_out = 0; m_en = 0; m_mask = 0;
      m_meth = 0; m_both = 0; m_type = 0; m_raw = 0; m_rd = 0; m_irq = 0;
    end else begin
      for (int i = 0; i < 32; i++) begin
        if (m_meth[i]) nraw[i] = m_s2[i] ^ m_type[i];
        else begin
          if (m_both[i]) hit = (m_s2[i] != m_prev[i]);
          else if (m_type[i]) hit = m_prev[i] && !m_s2[i];
          else hit = !m_prev[i] && m_s2[i];
          nraw[i] = hit || (m_raw[i] && !(wr_en && addr == 8'h30 && wdata[i]));
        end
      end
      m_irq = |(m_raw & m_en & ~m_mask);
      if (rd_en) begin
        case (addr)
          8'h04: rv = m_s2;
          8'h08: rv = m_dir;
          8'h10, 8'h14: rv = m_out;
          8'h20: rv = m_en;
          8'h24: rv = m_raw;
          8'h28: rv = m_raw & m_en & ~m_mask;
          8'h2C: rv = m_mask;
          8'h34: rv = m_meth;
          8'h38: rv = m_both;
          8'h3C: rv = m_type;
          default: rv = 0;
        endcase
        m_rd = rv;
      end
      if (wr_en) begin
        case (addr)
          8'h08: m_dir = wdata;
          8'h10: m_out = m_out | wdata;
          8'h14: m_out = m_out & ~wdata;
          8'h20: m_en = wdata;
          8'h2C: m_mask = wdata;
          8'h34: m_meth = wdata;
          8'h38: m_both = wdata;
          8'h3C: m_type = wdata;
          default: ;
        endcase
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in; m_raw = nraw;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    check("R2 pin_out vs model", pin_out, m_out);
    check("R3 pin_oe vs model", pin_oe, m_dir);
    check("R9 bank_irq vs model", {31'b0, bank_irq}, {31'b0, m_irq});
    check("R4 R5 R7 rdata vs model", rdata, m_rd);
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; wdata = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    check(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_tests;
    idle(3);
    rst = 0;
    check("R1 reset rdata", rdata, 0);
    check("R1 reset pin_oe", pin_oe, 0);
    check("R1 reset irq", {31'b0, bank_irq}, 0);
    rd(8'h08, 0, "R1 dir reset");
    rd(8'h34, 0, "R1 method reset");
    rd(8'h24, 0, "R1 raw reset");
    // direction and output
    wr(8'h08, 32'h0000_00FF);
    check("R3 pin_oe after write", pin_oe, 32'h0000_00FF);
    rd(8'h08, 32'h0000_00FF, "R3 dir readback");
    wr(8'h10, 32'h0F0F_0FF0);
    wr(8'h14, 32'h0000_0F00);
    check("R2 pin_out", pin_out, 32'h0F0F_00F0);
    rd(8'h10, 32'h0F0F_00F0, "R2 set-word readback");
    wr(8'h10, 32'h0000_0000);
    rd(8'h14, 32'h0F0F_00F0, "R2 zero bits keep");
    // input sync and rising edges
    pin_in = 32'hA5A5_0001;
    idle(4);
    rd(8'h04, 32'hA5A5_0001, "R4 input level");
    rd(8'h24, 32'hA5A5_0001, "R5 rising latched");
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h24, 0, "R8 clear all");
    // falling edge
    wr(8'h3C, 32'h1);
    pin_in = 32'hA5A5_0000;
    idle(4);
    rd(8'h24, 32'h1, "R5 falling latched");
    wr(8'h30, 32'h0);
    rd(8'h24, 32'h1, "R8 zero clear keeps");
    wr(8'h30, 32'h1);
    rd(8'h24, 0, "R8 one clears");
    // any edge
    wr(8'h38, 32'h2);
    wr(8'h3C, 32'h3);
    pin_in = 32'hA5A5_0002;
    idle(4);
    rd(8'h24, 32'h2, "R6 rise with any-edge");
    wr(8'h30, 32'h2);
    pin_in = 32'hA5A5_0000;
    idle(4);
    rd(8'h24, 32'h2, "R6 fall with any-edge");
    wr(8'h30, 32'h2);
    rd(8'h24, 0, "R8 any-edge cleared");
    // level mode
    wr(8'h34, 32'h10);
    idle(2);
    rd(8'h24, 0, "R7 level high inactive");
    pin_in = 32'hA5A5_0010;
    idle(4);
    rd(8'h24, 32'h10, "R7 level high active");
    wr(8'h30, 32'h10);
    rd(8'h24, 32'h10, "R7 clear no lasting effect");
    wr(8'h3C, 32'h13);
    idle(1);
    rd(8'h24, 0, "R7 active-low inactive");
    pin_in = 32'hA5A5_0000;
    idle(4);
    rd(8'h24, 32'h10, "R7 active-low active");
    // gating
    wr(8'h20, 32'h10);
    idle(2);
    check("R9 irq enabled", {31'b0, bank_irq}, 1);
    rd(8'h28, 32'h10, "R9 masked status");
    wr(8'h2C, 32'h10);
    idle(2);
    check("R9 irq masked", {31'b0, bank_irq}, 0);
    rd(8'h28, 0, "R9 masked status zero");
    // trigger vs clear collision
    wr(8'h34, 32'h0);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h24, 0, "R8 back to edge and cleared");
    pin_in = 32'hA5A5_0020;
    idle(2);
    wr(8'h30, 32'h20);
    rd(8'h24, 32'h20, "R10 trigger beats clear");
    wr(8'h30, 32'h20);
    rd(8'h24, 0, "R10 later clear removes");
    idle(3);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule